// File: doc/BRIEF.md
# Duty-Cycled Measurement Sequencer

This block paces a pulsed, low-power sensing front end. It runs from a free-running clock and opens a short active window at regular intervals. Each window starts with an offset-cancelling (auto-zero) phase and then moves to a measuring phase. Power to the sensing element and its comparators is enabled only while the window is open. The block gives a one-cycle strobe on the final measuring cycle, and downstream logic captures the comparator results on that strobe.

A static input selects slow operation, which doubles the interval between windows and so halves the sample rate. A new value of this input takes effect only when a period ends, so a window is never cut short by it. While an undervoltage flag is high the sequencer stays idle. Each time the flag falls, and after reset, a fixed ready delay must run out before the first window opens. All durations are clock-cycle counts set by parameters.

Top module: `hs_duty_sequencer`

## Requirements
- R1: While reset is active, every output is low, and the outputs stay low until the ready delay of R2 has run out.
- R2: After reset is released, or after `uv_i` falls, `trig_o` first rises immediately after the READY_CYC-th consecutive rising clock edge at which `uv_i` is sampled low.
- R3: With `slow_i` low, `trig_o` rises once every PERIOD_CYC cycles and stays high for exactly AZ_CYC + MEAS_CYC cycles, then stays low for the rest of the period.
- R4: With `slow_i` high, consecutive rises of `trig_o` are 2*PERIOD_CYC cycles apart, and the window length is unchanged.
- R5: Inside each window, `az_o` is high for the first AZ_CYC cycles and `meas_o` for the following MEAS_CYC cycles. The two are never high together and are never high outside the window.
- R6: `pwr_en_o` is high exactly when the window is open, that is, exactly when `az_o` or `meas_o` is high.
- R7: `smp_vld_o` is a single-cycle pulse on the last cycle of the measuring phase, once per window.
- R8: From the cycle after `uv_i` is sampled high, all outputs are low, even if a window was in progress, and they stay low while `uv_i` is high.
- R9: The value of `slow_i` sampled on the last cycle of a period sets the length of the next period. A change of `slow_i` during a period does not alter that period or its window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| slow_i | input | 1 | Static slow-mode select; high doubles the period |
| uv_i | input | 1 | Undervoltage flag, active high |
| trig_o | output | 1 | Active window (trigger) |
| az_o | output | 1 | Auto-zero phase |
| meas_o | output | 1 | Measuring phase |
| pwr_en_o | output | 1 | Power enable for the sensing element and comparators |
| smp_vld_o | output | 1 | One-cycle strobe on the last measuring cycle |

## Verification
Assertions check the following on every cycle:
- the phases are mutually exclusive and auto-zero precedes measuring;
- the strobe is a lone pulse inside the measuring phase;
- power follows the phases;
- the outputs go quiet one cycle after undervoltage;
- the period counter stays in range;
- the latched mode stays frozen inside a period.

The following can be shown only by the bench's scenarios, because they are absolute cycle counts:
- the exact ready latency;
- the normal and doubled spacing of windows;
- the window length;
- the one-period lag when slow mode is switched mid-window.

// File: rtl/hs_seq_pkg.sv
package hs_seq_pkg;

    typedef struct packed {
        logic trig;
        logic az;
        logic meas;
        logic pwr;
        logic smp;
    } phase_out_t;

endpackage

// File: rtl/hs_ready_gate.sv
module hs_ready_gate #(
    parameter int READY_CYC = 16
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic uv_i,
    output logic run_o
);
    localparam int RW = (READY_CYC > 1) ? $clog2(READY_CYC) : 1;
    localparam logic [RW-1:0] LAST = RW'(READY_CYC - 1);

    typedef struct packed {
        logic          run;
        logic [RW-1:0] cnt;
    } rg_t;

    rg_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (uv_i) begin
            st_d.run = 1'b0;
            st_d.cnt = '0;
        end else if (!st_q.run) begin
            if (st_q.cnt == LAST) begin
                st_d.run = 1'b1;
                st_d.cnt = '0;
            end else begin
                st_d.cnt = st_q.cnt + RW'(1);
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign run_o = st_q.run;

    assert_ready_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        uv_i |=> !run_o);

    assert_ready_release_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(run_o) |-> ($past(st_q.cnt) == LAST && !$past(uv_i)));

endmodule

// File: rtl/hs_period_timer.sv
module hs_period_timer #(
    parameter int PERIOD_CYC = 100,
    localparam int PW = $clog2(2 * PERIOD_CYC)
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          run_i,
    input  logic          slow_i,
    output logic [PW-1:0] pcnt_o
);
    localparam logic [PW-1:0] P_LAST = PW'(PERIOD_CYC - 1);
    localparam logic [PW-1:0] S_LAST = PW'(2 * PERIOD_CYC - 1);

    typedef struct packed {
        logic          slow;
        logic [PW-1:0] cnt;
    } pt_t;

    pt_t st_d, st_q;
    logic [PW-1:0] limit;

    always_comb begin
        limit = st_q.slow ? S_LAST : P_LAST;
        st_d  = st_q;
        if (!run_i) begin
            st_d.cnt  = '0;
            st_d.slow = slow_i;
        end else if (st_q.cnt == limit) begin
            st_d.cnt  = '0;
            st_d.slow = slow_i;
        end else begin
            st_d.cnt = st_q.cnt + PW'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign pcnt_o = st_q.cnt;

    assert_cnt_bound_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        run_i |-> (st_q.cnt <= (st_q.slow ? S_LAST : P_LAST)));

    assert_mode_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (run_i && $past(run_i) && st_q.cnt != '0) |-> $stable(st_q.slow));

endmodule

// File: rtl/hs_phase_decode.sv
module hs_phase_decode
    import hs_seq_pkg::*;
#(
    parameter int PERIOD_CYC = 100,
    parameter int AZ_CYC     = 2,
    parameter int MEAS_CYC   = 3,
    localparam int PW = $clog2(2 * PERIOD_CYC)
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          run_i,
    input  logic [PW-1:0] pcnt_i,
    output phase_out_t    ph_o
);
    localparam int WIN_CYC = AZ_CYC + MEAS_CYC;
    localparam logic [PW-1:0] AZ_END  = PW'(AZ_CYC);
    localparam logic [PW-1:0] WIN_END = PW'(WIN_CYC);
    localparam logic [PW-1:0] SMP_AT  = PW'(WIN_CYC - 1);

    always_comb begin
        ph_o      = '0;
        ph_o.trig = run_i && (pcnt_i < WIN_END);
        ph_o.az   = run_i && (pcnt_i < AZ_END);
        ph_o.meas = run_i && (pcnt_i >= AZ_END) && (pcnt_i < WIN_END);
        ph_o.pwr  = ph_o.az || ph_o.meas;
        ph_o.smp  = run_i && (pcnt_i == SMP_AT);
    end

    assert_phase_excl_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(ph_o.az && ph_o.meas));

    assert_trig_phase_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ph_o.trig |-> $onehot({ph_o.az, ph_o.meas}));

    assert_az_first_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(ph_o.meas) |-> $past(ph_o.az));

    assert_smp_in_meas_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ph_o.smp |-> ph_o.meas);

    assert_smp_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ph_o.smp |=> !ph_o.smp);

endmodule

// File: rtl/hs_duty_sequencer.sv
module hs_duty_sequencer
    import hs_seq_pkg::*;
#(
    parameter int PERIOD_CYC = 100,
    parameter int AZ_CYC     = 2,
    parameter int MEAS_CYC   = 3,
    parameter int READY_CYC  = 16
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic slow_i,
    input  logic uv_i,
    output logic trig_o,
    output logic az_o,
    output logic meas_o,
    output logic pwr_en_o,
    output logic smp_vld_o
);
    localparam int PW = $clog2(2 * PERIOD_CYC);

    logic          run;
    logic [PW-1:0] pcnt;
    phase_out_t    ph;

    hs_ready_gate #(.READY_CYC(READY_CYC)) u_ready (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .uv_i  (uv_i),
        .run_o (run)
    );

    hs_period_timer #(.PERIOD_CYC(PERIOD_CYC)) u_timer (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .run_i (run),
        .slow_i(slow_i),
        .pcnt_o(pcnt)
    );

    hs_phase_decode #(
        .PERIOD_CYC(PERIOD_CYC),
        .AZ_CYC    (AZ_CYC),
        .MEAS_CYC  (MEAS_CYC)
    ) u_decode (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .run_i (run),
        .pcnt_i(pcnt),
        .ph_o  (ph)
    );

    assign trig_o    = ph.trig;
    assign az_o      = ph.az;
    assign meas_o    = ph.meas;
    assign pwr_en_o  = ph.pwr;
    assign smp_vld_o = ph.smp;

    assert_pwr_window_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pwr_en_o |-> trig_o);

    assert_pwr_cover_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        trig_o |-> pwr_en_o);

    assert_uv_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        uv_i |=> (!pwr_en_o && !smp_vld_o && !trig_o));

endmodule

// File: tb/hs_duty_sequencer_bench.sv
module hs_duty_sequencer_bench;
    localparam int CLK_PERIOD = 10;
    localparam int P     = 100;
    localparam int AZ    = 2;
    localparam int MEAS  = 3;
    localparam int READY = 16;
    localparam int WIN   = AZ + MEAS;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic slow = 1'b0;
    logic uv = 1'b0;
    logic trig, az, meas, pwr, smp;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit done = 1'b0;
    bit rose = 1'b0;
    bit prev_trig = 1'b0;
    int rise_t = 0;
    int hi_cnt = 0;
    int last_win = 0;

    // reference state
    bit m_run = 1'b0;
    int m_rdy = 0;
    int m_pos = 0;
    bit m_slow = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    hs_duty_sequencer #(
        .PERIOD_CYC(P), .AZ_CYC(AZ), .MEAS_CYC(MEAS), .READY_CYC(READY)
    ) u_hs_duty_sequencer (
        .clk_i(clk), .rst_ni(rst_n), .slow_i(slow), .uv_i(uv),
        .trig_o(trig), .az_o(az), .meas_o(meas), .pwr_en_o(pwr), .smp_vld_o(smp)
    );

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_run <= 1'b0; m_rdy <= 0; m_pos <= 0; m_slow <= 1'b0;
        end else if (uv) begin
            m_run <= 1'b0; m_rdy <= 0; m_pos <= 0; m_slow <= slow;
        end else if (!m_run) begin
            m_pos <= 0; m_slow <= slow;
            if (m_rdy + 1 == READY) begin m_run <= 1'b1; m_rdy <= 0; end
            else m_rdy <= m_rdy + 1;
        end else begin
            if (m_pos + 1 == (m_slow ? 2 * P : P)) begin m_pos <= 0; m_slow <= slow; end
            else m_pos <= m_pos + 1;
        end
    end

    function automatic int exp_trig(); return int'(m_run && m_pos < WIN); endfunction
    function automatic int exp_az();   return int'(m_run && m_pos < AZ); endfunction
    function automatic int exp_meas(); return int'(m_run && m_pos >= AZ && m_pos < WIN); endfunction
    function automatic int exp_smp();  return int'(m_run && m_pos == WIN - 1); endfunction

    task automatic check(string req, int act, int expv);
        n_chk++;
        if (act != expv) begin
            n_fail++;
            $display("FAIL %s at cycle %0d: actual %0d expected %0d", req, cyc, act, expv);
        end
    endtask

    task automatic step();
        @(negedge clk);
        cyc++;
        check("R3 trig", int'(trig), exp_trig());
        check("R5 az", int'(az), exp_az());
        check("R5 meas", int'(meas), exp_meas());
        check("R6 pwr", int'(pwr), exp_trig());
        check("R7 smp", int'(smp), exp_smp());
        rose = trig && !prev_trig;
        if (rose) begin last_win = hi_cnt; hi_cnt = 1; end
        else if (trig) hi_cnt++;
        prev_trig = trig;
    endtask

    task automatic until_rise(output int gap);
        int t0 = cyc;
        do step(); while (!rose);
        gap = cyc - t0;
    endtask

    initial begin
        int gap;
        int k;
        void'($urandom(32'd20240517));
        repeat (3) begin
            @(negedge clk);
            check("R1 reset quiet", int'(trig | az | meas | pwr | smp), 0);
        end
        rst_n = 1'b1;
        // R2: ready latency after reset
        until_rise(gap);
        check("R2 ready after reset", gap, READY);
        // R3: period and window length
        until_rise(gap);
        check("R3 normal period", gap, P);
        check("R3 window length", last_win, WIN);
        // R9 / R4: slow raised mid-window takes effect one period later
        slow = 1'b1;
        until_rise(gap);
        check("R9 current period kept", gap, P);
        until_rise(gap);
        check("R4 slow period", gap, 2 * P);
        check("R4 slow window length", last_win, WIN);
        slow = 1'b0;
        until_rise(gap);
        check("R9 slow period kept", gap, 2 * P);
        until_rise(gap);
        check("R3 back to normal", gap, P);
        // R8: undervoltage in the auto-zero phase
        uv = 1'b1;
        step();
        check("R8 cut window", int'(trig | az | meas | pwr | smp), 0);
        for (int i = 0; i < 20; i++) begin
            step();
            check("R8 stays quiet", int'(trig | pwr), 0);
        end
        uv = 1'b0;
        until_rise(gap);
        check("R2 ready after undervoltage", gap, READY);
        // R8: short undervoltage pulse during ready count restarts it
        uv = 1'b1;
        step();
        uv = 1'b0;
        k = 0;
        repeat (READY - 3) begin step(); k++; end
        uv = 1'b1;
        step();
        uv = 1'b0;
        until_rise(gap);
        check("R2 ready restarts", gap, READY);
        // random mix, checked against the reference each cycle
        for (int i = 0; i < 6000; i++) begin
            int r;
            step();
            r = int'($urandom % 1000);
            if (!uv && r < 3) uv = 1'b1;
            else if (uv && r < 120) uv = 1'b0;
            if ($urandom % 350 == 0) slow = ~slow;
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule